// File: doc/BRIEF.md
# Serial ADC Host Controller with Sleep and Wake Sequencing

This block is the host side of a three-wire link to a sampling converter with a resolution of 12, 10 or 8 bits. It drives an active-low chip select and a serial clock, samples the converter's data line and delivers each conversion as a right-justified parallel word with a one-cycle valid strobe. The serial clock comes from the system clock: each half period lasts `HALF_DIV` system cycles. The converter changes its data on the falling serial edge, so the controller samples on the rising edge.

Two kinds of request start a frame. A start request runs a full conversion frame. A sleep request runs a frame that releases chip select after the fifth falling edge. That point lies inside the window in which the converter powers down, with margin on both sides. An internal flag records that the converter is asleep. The next start request then runs a wake-up frame first, whose data is thrown away, and then runs the real conversion at once. The user sees only the second result.

States: IDLE (select high, clock high), SETUP (select low, one half period before the first falling edge), LOW and HIGH (the two clock phases), CUT (select raised early in a sleep frame), GAP (select high for one half period after a full frame). Transitions: IDLE→SETUP on a request; SETUP→LOW, LOW→HIGH and HIGH→LOW on divider ticks; LOW→CUT on the tick after the fifth falling edge of a sleep frame; HIGH→GAP after the sixteenth falling edge; CUT→IDLE; GAP→SETUP after a wake-up frame, otherwise GAP→IDLE.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset and whenever no frame runs, `csn_o` and `sclk_o` are both high, `sample_vld_o` is low, and `sample_o` is zero until the first result arrives.
- R2: A start request while idle and awake runs one frame. In that frame `csn_o` stays low for exactly 16 falling edges of `sclk_o`. Consecutive falling edges are 2×`HALF_DIV` system cycles apart.
- R3: `sdo_i` is sampled at each rising edge of `sclk_o`. Counting the sample after the k-th falling edge as sample k, the result is made of samples 4 to 3+N with the first of them as MSB. N is 12 when `res_sel_i`=0, 10 when it is 1, and 8 when it is 2 or 3. The result is right-justified and its upper bits are zero, whatever the other samples hold.
- R4: Each real frame ends with `sample_vld_o` high for one cycle while `csn_o` is high. `sample_o` changes only in that cycle.
- R5: A sleep request while idle and awake runs a frame that raises `csn_o` after exactly 5 falling edges, before a sixth. No valid strobe follows that frame.
- R6: After a sleep frame, a start request runs two full 16-edge frames in a row. Only the second frame's data is reported, with one strobe. After that the converter counts as awake, and the next start runs a single frame.
- R7: When start and sleep are requested in the same idle cycle, the start is served and the sleep request is dropped.
- R8: Start and sleep requests that arrive while a frame runs are ignored.
- R9: A sleep request while the converter is already asleep causes no activity on `csn_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion (one-cycle pulse) |
| sleep_i | input | 1 | Request converter power-down (one-cycle pulse) |
| res_sel_i | input | 2 | Resolution: 0 = 12 bit, 1 = 10 bit, 2 or 3 = 8 bit |
| sdo_i | input | 1 | Serial data from the converter |
| csn_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| sample_o | output | MAX_BITS | Last valid conversion, right-justified |
| sample_vld_o | output | 1 | One-cycle strobe for a new result |

## Verification
The two functions that can fall in the same cycle are a start and a sleep request. They can meet in one idle cycle, and either one can also arrive while the other's frame runs. The bench raises both together while idle and judges the outcome from the edge count of the frame, the strobe, and whether the next start needs a wake-up frame. It also repeats the pair in the middle of a running frame and checks that neither the frame length nor the sleep state changes.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_CUT,
        ST_GAP
    } link_state_e;

    typedef enum logic [1:0] {
        FK_REAL,
        FK_DUMMY,
        FK_SLEEP
    } frame_kind_e;

    // Number of result bits for a resolution code, counted down from the widest.
    function automatic int res_width(input logic [1:0] sel, input int max_bits);
        int step;
        unique case (sel)
            2'd0:    step = 0;
            2'd1:    step = 1;
            default: step = 2;
        endcase
        return max_bits - 2 * step;
    endfunction

endpackage

// File: rtl/adc_link_tick.sv
module adc_link_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_link_capture.sv
module adc_link_capture #(
    parameter int MAX_BITS  = 12,
    parameter int LEAD_BITS = 3,
    parameter int IDX_W     = 5,
    parameter int NB_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                strobe,
    input  logic [IDX_W-1:0]    idx,
    input  logic [NB_W-1:0]     nbits,
    input  logic                din,
    output logic [MAX_BITS-1:0] word
);
    logic [MAX_BITS-1:0] shr_q;
    logic                in_window;

    // Only samples inside the result window enter the register, so bits
    // outside it never reach the word and the result is right-justified.
    always_comb begin
        in_window = (int'(idx) > LEAD_BITS) &&
                    (int'(idx) <= LEAD_BITS + int'(nbits));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shr_q <= '0;
        end else if (clr) begin
            shr_q <= '0;
        end else if (strobe && in_window) begin
            shr_q <= {shr_q[MAX_BITS-2:0], din};
        end
    end

    assign word = shr_q;
endmodule

// File: rtl/adc_link_fsm.sv
module adc_link_fsm
    import adc_link_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int CUT_EDGE  = 5,
    parameter int MAX_BITS  = 12,
    parameter int IDX_W     = 5,
    parameter int NB_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sleep_i,
    input  logic [1:0]       res_i,
    input  logic             tick,
    output logic             run_o,
    output logic             csn_o,
    output logic             sclk_o,
    output logic             sample_stb_o,
    output logic             frame_clr_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NB_W-1:0]  nbits_o,
    output logic             post_o
);
    link_state_e state_q, state_d;
    frame_kind_e kind_q, kind_d;
    logic             asleep_q;
    logic [IDX_W-1:0] falls_q;
    logic [1:0]       res_q;
    logic             csn_q, sclk_q;
    logic             last_edge, cut_edge;

    assign last_edge = (falls_q == IDX_W'(FRAME_LEN));
    assign cut_edge  = (falls_q == IDX_W'(CUT_EDGE));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SETUP;
                    kind_d  = asleep_q ? FK_DUMMY : FK_REAL;
                end else if (sleep_i && !asleep_q) begin
                    state_d = ST_SETUP;
                    kind_d  = FK_SLEEP;
                end
            end
            ST_SETUP: begin
                if (tick) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (tick) begin
                    if (kind_q == FK_SLEEP && cut_edge) state_d = ST_CUT;
                    else                                state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (last_edge) state_d = ST_GAP;
                    else           state_d = ST_LOW;
                end
            end
            ST_CUT: begin
                if (tick) state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (tick) begin
                    if (kind_q == FK_DUMMY) begin
                        state_d = ST_SETUP;
                        kind_d  = FK_REAL;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= FK_REAL;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // Frame bookkeeping: falling-edge count, sleep flag, latched resolution
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            falls_q  <= '0;
            asleep_q <= 1'b0;
            res_q    <= 2'd0;
        end else begin
            if (state_d == ST_SETUP && state_q != ST_SETUP) begin
                falls_q <= '0;
            end else if (state_d == ST_LOW && state_q != ST_LOW) begin
                falls_q <= falls_q + 1'b1;
            end
            if (state_q == ST_IDLE && state_d == ST_SETUP) begin
                res_q <= res_i;
            end
            if (state_q == ST_LOW && state_d == ST_CUT) begin
                asleep_q <= 1'b1;
            end else if (state_q == ST_GAP && tick && kind_q == FK_DUMMY) begin
                asleep_q <= 1'b0;
            end
        end
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            unique case (state_d)
                ST_IDLE, ST_CUT, ST_GAP: csn_q <= 1'b1;
                default:                 csn_q <= 1'b0;
            endcase
            sclk_q <= (state_d != ST_LOW);
        end
    end

    assign csn_o        = csn_q;
    assign sclk_o       = sclk_q;
    assign run_o        = (state_q != ST_IDLE);
    assign sample_stb_o = (state_q == ST_LOW) && (state_d == ST_HIGH);
    assign frame_clr_o  = (state_d == ST_SETUP) && (state_q != ST_SETUP);
    assign idx_o        = falls_q;
    assign nbits_o      = NB_W'(res_width(res_q, MAX_BITS));
    assign post_o       = (state_q == ST_HIGH) && tick && last_edge && (kind_q == FK_REAL);
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl #(
    parameter int HALF_DIV  = 2,
    parameter int FRAME_LEN = 16,
    parameter int LEAD_BITS = 3,
    parameter int CUT_EDGE  = 5,
    parameter int MAX_BITS  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                sleep_i,
    input  logic [1:0]          res_sel_i,
    input  logic                sdo_i,
    output logic                csn_o,
    output logic                sclk_o,
    output logic [MAX_BITS-1:0] sample_o,
    output logic                sample_vld_o
);
    localparam int IDX_W = $clog2(FRAME_LEN + 1);
    localparam int NB_W  = $clog2(MAX_BITS + 1);

    logic             run, tick, stb, clr, post;
    logic [IDX_W-1:0] idx;
    logic [NB_W-1:0]  nbits;
    logic [MAX_BITS-1:0] word;
    logic [MAX_BITS-1:0] sample_q;
    logic                vld_q;

    adc_link_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .tick  (tick)
    );

    adc_link_fsm #(
        .FRAME_LEN (FRAME_LEN),
        .CUT_EDGE  (CUT_EDGE),
        .MAX_BITS  (MAX_BITS),
        .IDX_W     (IDX_W),
        .NB_W      (NB_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sleep_i      (sleep_i),
        .res_i        (res_sel_i),
        .tick         (tick),
        .run_o        (run),
        .csn_o        (csn_o),
        .sclk_o       (sclk_o),
        .sample_stb_o (stb),
        .frame_clr_o  (clr),
        .idx_o        (idx),
        .nbits_o      (nbits),
        .post_o       (post)
    );

    adc_link_capture #(
        .MAX_BITS  (MAX_BITS),
        .LEAD_BITS (LEAD_BITS),
        .IDX_W     (IDX_W),
        .NB_W      (NB_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .strobe (stb),
        .idx    (idx),
        .nbits  (nbits),
        .din    (sdo_i),
        .word   (word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= post;
            if (post) sample_q <= word;
        end
    end

    assign sample_o     = sample_q;
    assign sample_vld_o = vld_q;
endmodule

// File: rtl/adc_link_chk.sv
module adc_link_chk #(
    parameter int FRAME_LEN = 16,
    parameter int CUT_EDGE  = 5,
    parameter int MAX_BITS  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                csn_o,
    input logic                sclk_o,
    input logic                sample_vld_o,
    input logic [MAX_BITS-1:0] sample_o
);
    localparam int CW = $clog2(FRAME_LEN + 2);

    logic [CW-1:0] edges_q;
    logic          sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_q     <= '0;
            sclk_prev_q <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_o;
            if (csn_o)                       edges_q <= '0;
            else if (sclk_prev_q && !sclk_o) edges_q <= edges_q + 1'b1;
        end
    end

    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> sclk_o);                                                    // R1
    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= CW'(FRAME_LEN));                                           // R2
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !sample_vld_o);                                      // R4
    AST_VLD_WITH_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> csn_o);                                              // R4
    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_o |-> $stable(sample_o));                                 // R4
    AST_CS_RELEASE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> (edges_q == CW'(FRAME_LEN) || edges_q == CW'(CUT_EDGE))); // R5
    AST_NO_VLD_AFTER_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> (edges_q == CW'(FRAME_LEN)));                        // R5
endmodule

bind adc_link_ctrl adc_link_chk #(
    .FRAME_LEN (FRAME_LEN),
    .CUT_EDGE  (CUT_EDGE),
    .MAX_BITS  (MAX_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_o        (csn_o),
    .sclk_o       (sclk_o),
    .sample_vld_o (sample_vld_o),
    .sample_o     (sample_o)
);

// File: tb/sim_adc_link_ctrl.sv
module sim_adc_link_ctrl;
    localparam int HALF = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sleep = 1'b0;
    logic [1:0]  res   = 2'd0;
    logic        sdo   = 1'b1;
    logic        csn, sclk, vld;
    logic [11:0] sample;

    adc_link_ctrl #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sleep_i(sleep),
        .res_sel_i(res), .sdo_i(sdo), .csn_o(csn), .sclk_o(sclk),
        .sample_o(sample), .sample_vld_o(vld)
    );

    int checks = 0;
    int fails  = 0;

    // Converter model and observers
    int code_a = 0, code_b = 0, nb_model = 12, seq = 0, kidx = 0;
    int frames = 0, fr_edges = 0, vld_cnt = 0, last_val = 0;
    int bad_space = 0, last_fall = 0, cyc = 0;
    int edges_log [0:3];
    logic csn_p = 1'b1, sclk_p = 1'b1;

    function automatic logic model_bit(int k);
        int code;
        code = (seq <= 1) ? code_a : code_b;
        if (k >= 4 && k <= 3 + nb_model) return code[nb_model - 1 - (k - 4)];
        return 1'b1;   // garbage outside the result window
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 190000);
            summary();
        end
        if (csn_p && !csn) begin
            seq++; kidx = 0; fr_edges = 0; sdo = 1'b1;
        end
        if (!csn && sclk_p && !sclk) begin
            kidx++; fr_edges++;
            if (fr_edges > 1 && (cyc - last_fall) != 2 * HALF) bad_space++;
            last_fall = cyc;
            sdo = model_bit(kidx);
        end
        if (!csn_p && csn) begin
            if (frames < 4) edges_log[frames] = fr_edges;
            frames++;
        end
        if (vld) begin vld_cnt++; last_val = int'(sample); end
        csn_p = csn; sclk_p = sclk;
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear();
        frames = 0; vld_cnt = 0; seq = 0;
    endtask

    task automatic pulse(bit s, bit sl);
        @(negedge clk); start = s; sleep = sl;
        @(negedge clk); start = 1'b0; sleep = 1'b0;
    endtask

    task automatic run_frame(logic [1:0] r, int code, int n);
        clear(); res = r; code_a = code; nb_model = n;
        pulse(1'b1, 1'b0);
        repeat (110) @(negedge clk);
        chk(frames == 1, "R2 frame count", frames, 1);
        chk(edges_log[0] == 16, "R2 falling edges", edges_log[0], 16);
        chk(vld_cnt == 1, "R4 strobe count", vld_cnt, 1);
        chk(last_val == (code & ((1 << n) - 1)), "R3 result", last_val, code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(csn && sclk && !vld && sample == 0, "R1 reset state",
            int'({csn, sclk, vld}), 6);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(csn && sclk && !vld && sample == 0, "R1 idle state",
            int'({csn, sclk, vld}), 6);

        // R3 sweeps at each resolution
        for (int i = 0; i < 256; i++) run_frame(2'd2, i, 8);
        run_frame(2'd3, 8'hA5, 8);
        for (int i = 0; i < 64; i++) run_frame(2'd1, (i * 16 | (i & 15)) & 10'h3FF, 10);
        for (int i = 0; i < 64; i++) run_frame(2'd0, (i * 65) & 12'hFFF, 12);

        // R5: sleep frame
        clear(); res = 2'd0; nb_model = 12;
        pulse(1'b0, 1'b1);
        repeat (110) @(negedge clk);
        chk(frames == 1, "R5 sleep frame count", frames, 1);
        chk(edges_log[0] == 5, "R5 edges before release", edges_log[0], 5);
        chk(vld_cnt == 0, "R5 no strobe", vld_cnt, 0);

        // R9: sleep while asleep
        clear();
        pulse(1'b0, 1'b1);
        repeat (110) @(negedge clk);
        chk(frames == 0, "R9 no activity", frames, 0);

        // R6: wake-up frame then real frame
        clear(); code_a = 12'h0F0; code_b = 12'h5A3;
        pulse(1'b1, 1'b0);
        repeat (250) @(negedge clk);
        chk(frames == 2, "R6 two frames", frames, 2);
        chk(edges_log[0] == 16, "R6 dummy edges", edges_log[0], 16);
        chk(edges_log[1] == 16, "R6 real edges", edges_log[1], 16);
        chk(vld_cnt == 1, "R6 one strobe", vld_cnt, 1);
        chk(last_val == 12'h5A3, "R6 second frame data", last_val, 12'h5A3);
        run_frame(2'd0, 12'h9C1, 12);   // R6: awake again, single frame

        // R7: start and sleep together
        clear(); code_a = 12'h321;
        pulse(1'b1, 1'b1);
        repeat (110) @(negedge clk);
        chk(frames == 1 && edges_log[0] == 16, "R7 start served", edges_log[0], 16);
        chk(vld_cnt == 1 && last_val == 12'h321, "R7 result", last_val, 12'h321);
        run_frame(2'd0, 12'h432, 12);   // R7: sleep dropped, no wake-up frame

        // R8: requests during a frame
        clear(); code_a = 12'h777;
        pulse(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        pulse(1'b1, 1'b1);
        repeat (110) @(negedge clk);
        chk(frames == 1, "R8 single frame", frames, 1);
        chk(edges_log[0] == 16, "R8 full length", edges_log[0], 16);
        chk(vld_cnt == 1 && last_val == 12'h777, "R8 result", last_val, 12'h777);
        run_frame(2'd0, 12'h1E5, 12);   // R8: sleep was not taken

        chk(bad_space == 0, "R2 clock spacing", bad_space, 0);
        summary();
    end
endmodule